// File: doc/BRIEF.md
# Banked UART Register Access Decoder

This block sits between a byte-wide CPU port and the register file of a UART. It owns the line-control byte and the extra-feature control byte, and uses them to choose which of six register banks a 3-bit address reaches. Each cycle it raises the write strobe of the visible bank, and it returns read data from the visible bank one clock after a read request. The registers inside each bank are held elsewhere. They receive the shared address, the write data and their own strobe, and they present their read data on a shared bus.

Bank choice follows a fixed priority. The highest is a full-byte match of the line-control value against a magic code. Next come the two extra-feature banks, then the special bank, then the divisor bank, and last the normal bank. The line-control byte stays at its own address in every bank. The extra-feature control byte can be reached from every bank except the normal one, so software can always step through the divisor bank to change it. Unmapped locations read as zero, and writes to them are dropped.

Top module: `uart_bank_decoder`

## Requirements
- R1: After reset both control bytes are 0x00, the normal bank is active (`bank_active` = 6'b000001) and `rdata` is 0x00.
- R2: The line-control byte sits at address 3 in every bank. A write there loads it at the next clock edge, and a read returns it.
- R3: The extra-feature control byte sits at address 2 in every bank except the normal one. In the normal bank, address 2 belongs to the bank and a write there leaves the control byte unchanged.
- R4: While the line-control byte equals 0xBF, the enhanced bank (index 2) is active, whatever the extra-feature byte holds.
- R5: When R4 does not apply, extra-feature bits [2:1] = 01 select extra bank one (index 4) and bits [2:1] = 10 select extra bank two (index 5).
- R6: When R4 and R5 do not apply and extra-feature bit 0 is 1, the special bank (index 3) is active.
- R7: When R4 to R6 do not apply, line-control bit 7 = 1 selects the divisor bank (index 1). Otherwise the normal bank (index 0) is active.
- R8: The addresses mapped into each bank are: normal 0,1,2,4,5,6,7; divisor 0,1; enhanced 0,1,4,5,6,7; special 0,4,5; extra one 0,1,4,5; extra two 1,4,5,6,7. A read of any other address that is not a control byte returns 0x00.
- R9: `bank_we[k]` is high in the same cycle as `wr_en` exactly when bank k is active and the address is mapped into it. Otherwise all strobes stay low, including for control-byte and unmapped writes.
- R10: A read sets `rdata` at the next clock edge. For a mapped address the value comes from `bank_rdata[8k+7:8k]` of the active bank k. Without `rd_en`, `rdata` holds its value.
- R11: A read and a write to the same control address in one cycle return the value from before the write, and the new value selects the bank from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| wdata | input | 8 | Write data |
| bank_rdata | input | 48 | Read data of the six banks, bank k in bits 8k+7:8k |
| rdata | output | 8 | Registered read data |
| bank_we | output | 6 | Per-bank write strobe |
| bank_active | output | 6 | One-hot visible bank |

## Verification
A single cycle can hold both a read and a write that changes the bank selection. The bench sets the line-control byte to a known value, then raises `rd_en` and `wr_en` together at address 3 with a new value. It expects the old value on `rdata` at the following edge and the new bank on `bank_active` right after. It also runs a full sweep of control values and addresses, with every expected strobe and read value worked out from the priority rules and the bank maps.

// File: rtl/uart_bank_pkg.sv
package uart_bank_pkg;
  localparam int DW      = 8;
  localparam int AW      = 3;
  localparam int NLOC    = 1 << AW;
  localparam int NBANK   = 6;

  typedef enum logic [2:0] {
    BK_NORMAL   = 3'd0,
    BK_DIVISOR  = 3'd1,
    BK_ENHANCED = 3'd2,
    BK_SPECIAL  = 3'd3,
    BK_XTRA1    = 3'd4,
    BK_XTRA2    = 3'd5
  } bank_e;

  // Bit i set: address i is a register of the bank.
  function automatic logic [NLOC-1:0] bank_map(input bank_e b);
    logic [NLOC-1:0] m;
    case (b)
      BK_NORMAL:   m = 8'hF7;
      BK_DIVISOR:  m = 8'h03;
      BK_ENHANCED: m = 8'hF3;
      BK_SPECIAL:  m = 8'h31;
      BK_XTRA1:    m = 8'h33;
      BK_XTRA2:    m = 8'hF2;
      default:     m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/ubd_ctrl_regs.sv
module ubd_ctrl_regs
  import uart_bank_pkg::*;
#(
  parameter logic [AW-1:0] LCR_ADDR  = 3'd3,
  parameter logic [AW-1:0] EFCR_ADDR = 3'd2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          efcr_vis,
  output logic [DW-1:0] lcr_q,
  output logic [DW-1:0] efcr_q
);
  logic          lcr_ld;
  logic          efcr_ld;
  logic [DW-1:0] lcr_d;
  logic [DW-1:0] efcr_d;

  always_comb begin
    lcr_ld  = wr_en && (addr == LCR_ADDR);
    efcr_ld = wr_en && (addr == EFCR_ADDR) && efcr_vis;
    lcr_d   = lcr_ld  ? wdata : lcr_q;
    efcr_d  = efcr_ld ? wdata : efcr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr_q  <= '0;
      efcr_q <= '0;
    end else begin
      lcr_q  <= lcr_d;
      efcr_q <= efcr_d;
    end
  end

  AST_LCR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == LCR_ADDR) |=> (lcr_q == $past(wdata))); // R2
  AST_EFCR_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == EFCR_ADDR && !efcr_vis) |=> $stable(efcr_q)); // R3
endmodule

// File: rtl/ubd_bank_sel.sv
module ubd_bank_sel
  import uart_bank_pkg::*;
#(
  parameter logic [DW-1:0] MAGIC_LCR = 8'hBF
) (
  input  logic [DW-1:0]    lcr_q,
  input  logic [DW-1:0]    efcr_q,
  output bank_e            bank,
  output logic [NBANK-1:0] bank_oh
);
  always_comb begin
    if (lcr_q == MAGIC_LCR)        bank = BK_ENHANCED;
    else if (efcr_q[2:1] == 2'b01) bank = BK_XTRA1;
    else if (efcr_q[2:1] == 2'b10) bank = BK_XTRA2;
    else if (efcr_q[0])            bank = BK_SPECIAL;
    else if (lcr_q[DW-1])          bank = BK_DIVISOR;
    else                           bank = BK_NORMAL;
  end

  for (genvar k = 0; k < NBANK; k++) begin : g_oh
    assign bank_oh[k] = (bank == bank_e'(k));
  end
endmodule

// File: rtl/ubd_access_route.sv
module ubd_access_route
  import uart_bank_pkg::*;
#(
  parameter logic [AW-1:0] LCR_ADDR  = 3'd3,
  parameter logic [AW-1:0] EFCR_ADDR = 3'd2,
  parameter logic [DW-1:0] MAGIC_LCR = 8'hBF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       addr,
  input  logic                wr_en,
  input  logic                rd_en,
  input  bank_e               bank,
  input  logic [NBANK-1:0]    bank_oh,
  input  logic [DW-1:0]       lcr_q,
  input  logic [DW-1:0]       efcr_q,
  input  logic [NBANK*DW-1:0] bank_rdata,
  output logic [NBANK-1:0]    bank_we,
  output logic [DW-1:0]       rdata
);
  logic [NLOC-1:0] map_now;
  logic            mapped;
  logic            hit_lcr;
  logic            hit_efcr;
  logic [DW-1:0]   rd_mux;
  logic [DW-1:0]   rdata_d;

  always_comb begin
    map_now  = bank_map(bank);
    hit_lcr  = (addr == LCR_ADDR);
    hit_efcr = (addr == EFCR_ADDR) && (bank != BK_NORMAL);
    mapped   = map_now[addr] && !hit_lcr && !hit_efcr;
    rd_mux   = bank_rdata[bank*DW +: DW];
  end

  for (genvar k = 0; k < NBANK; k++) begin : g_we
    assign bank_we[k] = wr_en && mapped && bank_oh[k];
  end

  always_comb begin
    if (!rd_en)        rdata_d = rdata;
    else if (hit_lcr)  rdata_d = lcr_q;
    else if (hit_efcr) rdata_d = efcr_q;
    else if (mapped)   rdata_d = rd_mux;
    else               rdata_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_d;
  end

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we)); // R9
  AST_WE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (bank_we == '0)); // R9
  AST_MAGIC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (lcr_q == MAGIC_LCR) |-> (bank_oh[BK_ENHANCED] && $countones(bank_oh) == 1)); // R4
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !mapped && !hit_lcr && !hit_efcr) |=> (rdata == '0)); // R8
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R10
endmodule

// File: rtl/uart_bank_decoder.sv
module uart_bank_decoder
  import uart_bank_pkg::*;
#(
  parameter logic [AW-1:0] LCR_ADDR  = 3'd3,
  parameter logic [AW-1:0] EFCR_ADDR = 3'd2,
  parameter logic [DW-1:0] MAGIC_LCR = 8'hBF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       addr,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [DW-1:0]       wdata,
  input  logic [NBANK*DW-1:0] bank_rdata,
  output logic [DW-1:0]       rdata,
  output logic [NBANK-1:0]    bank_we,
  output logic [NBANK-1:0]    bank_active
);
  logic          rst_meta;
  logic          rst_sync_n;
  logic [DW-1:0] lcr_q;
  logic [DW-1:0] efcr_q;
  bank_e         bank;

  // Asynchronous assertion, release aligned to the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  ubd_ctrl_regs #(.LCR_ADDR(LCR_ADDR), .EFCR_ADDR(EFCR_ADDR)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .wdata    (wdata),
    .efcr_vis (!bank_active[BK_NORMAL]),
    .lcr_q    (lcr_q),
    .efcr_q   (efcr_q)
  );

  ubd_bank_sel #(.MAGIC_LCR(MAGIC_LCR)) u_sel (
    .lcr_q   (lcr_q),
    .efcr_q  (efcr_q),
    .bank    (bank),
    .bank_oh (bank_active)
  );

  ubd_access_route #(.LCR_ADDR(LCR_ADDR), .EFCR_ADDR(EFCR_ADDR),
                     .MAGIC_LCR(MAGIC_LCR)) u_route (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .addr       (addr),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .bank       (bank),
    .bank_oh    (bank_active),
    .lcr_q      (lcr_q),
    .efcr_q     (efcr_q),
    .bank_rdata (bank_rdata),
    .bank_we    (bank_we),
    .rdata      (rdata)
  );

  AST_BANK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones(bank_active) == 1); // R7
  AST_XTRA_OVER_SPECIAL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lcr_q != MAGIC_LCR && efcr_q[2:1] == 2'b10) |-> bank_active[BK_XTRA2]); // R5
endmodule

// File: tb/uart_bank_decoder_tb.sv
module uart_bank_decoder_tb;
  logic        clk;
  logic        rst_n;
  logic [2:0]  addr;
  logic        wr_en;
  logic        rd_en;
  logic [7:0]  wdata;
  logic [47:0] bank_rdata;
  logic [7:0]  rdata;
  logic [5:0]  bank_we;
  logic [5:0]  bank_active;
  int          n_cmp;
  int          n_bad;

  uart_bank_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .bank_rdata(bank_rdata), .rdata(rdata),
    .bank_we(bank_we), .bank_active(bank_active)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Each bank answers with its index + 1 in the high nibble and the address below.
  always_comb begin
    for (int k = 0; k < 6; k++) bank_rdata[k*8 +: 8] = {4'(k + 1), 1'b0, addr};
  end

  function automatic int exp_bank(input logic [7:0] l, input logic [7:0] e);
    if (l == 8'hBF)          return 2;
    if (e[2:1] == 2'b01)     return 4;
    if (e[2:1] == 2'b10)     return 5;
    if (e[0])                return 3;
    if (l[7])                return 1;
    return 0;
  endfunction

  function automatic logic [7:0] exp_mask(input int b);
    case (b)
      0: return 8'hF7;  1: return 8'h03;  2: return 8'hF3;
      3: return 8'h31;  4: return 8'h33;  default: return 8'hF2;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at a falling edge.
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic setup(input logic [7:0] l, input logic [7:0] e);
    wr(3'd3, 8'h80);
    wr(3'd2, e);
    wr(3'd3, l);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] lv [7];
    n_cmp = 0; n_bad = 0;
    addr = '0; wr_en = 0; rd_en = 0; wdata = '0; rst_n = 0;
    lv = '{8'h00, 8'h03, 8'h80, 8'h83, 8'hBF, 8'h3F, 8'hFF};
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1
    chk("R1 bank_active", {2'b0, bank_active}, 8'h01);
    chk("R1 rdata", rdata, 8'h00);
    rd(3'd3);
    chk("R1 lcr", rdata, 8'h00);

    // R3: address 2 in normal bank strobes the bank, not the control byte
    addr = 3'd2; wdata = 8'h06; wr_en = 1'b1; #1;
    chk("R3 normal addr2 strobe", {2'b0, bank_we}, 8'h01);
    @(negedge clk); wr_en = 1'b0;
    chk("R3 bank unchanged", {2'b0, bank_active}, 8'h01);
    wr(3'd3, 8'h80);
    rd(3'd2);
    chk("R3 efcr kept", rdata, 8'h00);

    // R4..R10 sweep
    foreach (lv[i]) begin
      for (int e = 0; e < 8; e++) begin
        int b;
        logic [7:0] m;
        setup(lv[i], 8'(e));
        b = exp_bank(lv[i], 8'(e));
        m = exp_mask(b);
        chk("R4-sel R5 R6 R7 bank_active", {2'b0, bank_active}, 8'(1 << b));
        for (int a = 0; a < 8; a++) begin
          logic [7:0] er;
          logic       mp;
          mp = m[a];
          // write probe, withdrawn before the edge
          addr = 3'(a); wdata = 8'h5A; wr_en = 1'b1; #1;
          chk("R9 bank_we", {2'b0, bank_we}, mp ? 8'(1 << b) : 8'h00);
          wr_en = 1'b0;
          @(negedge clk);
          rd(3'(a));
          if (a == 3)                er = lv[i];
          else if (a == 2 && b != 0) er = 8'(e);
          else if (mp)               er = {4'(b + 1), 1'b0, 3'(a)};
          else                       er = 8'h00;
          chk("R2 R3 R8 R10 rdata", rdata, er);
          @(negedge clk);
          chk("R10 rdata hold", rdata, er);
        end
      end
    end

    // R11: read and write of line-control in the same cycle
    setup(8'h80, 8'h00);
    addr = 3'd3; wdata = 8'hBF; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R11 old value read", rdata, 8'h80);
    chk("R11 new bank", {2'b0, bank_active}, 8'h04);
    rd(3'd3);
    chk("R11 new value", rdata, 8'hBF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule